// File: doc/BRIEF.md
# Interlaced Field Parity Detector

This block tells the two fields of an interlaced picture apart by looking only at the timing of an active-low vertical sync and an active-low horizontal sync, both synchronous to the pixel clock. It counts clocks between successive horizontal falling edges to learn the line length. When a vertical falling edge arrives, it takes the clock offset since the latest horizontal falling edge and places it as a fraction of that learned length. An offset in the early part of the line gives one field type. An offset in the late part gives the other. A dead band surrounds both acceptance windows, and an offset that lands in it is reported as an error rather than guessed.

The window limits are parameters given in parts of a fixed scale (thousandths by default). The test is done by cross-multiplying the offset and the period against the limits, so no divider is needed. One instance handles one sync pair, so a system with a main and an inset picture uses two instances. The horizontal input must already be free of equalizing pulses, because every horizontal falling edge is taken as the start of a line.

Top module: `field_parity_det`

## Requirements
- R1: During and after reset, `field_par`, `field_vld` and `phase_err` are all 0.
- R2: The line period is the number of clocks between two consecutive `hsync_n` falling edges. A single edge after reset, or after a loss of sync, gives no period. A `vsync_n` falling edge seen with no period known sets `phase_err` to 1, gives no `field_vld`, and leaves `field_par` unchanged.
- R3: If the vertical offset (clocks from the latest `hsync_n` falling edge to the `vsync_n` falling edge) lies in the early window, from 0.02 to 0.40 of the period, `field_vld` pulses, `field_par` becomes 0 and `phase_err` becomes 0.
- R4: If the offset lies in the late window, from 0.60 to 0.98 of the period, `field_vld` pulses, `field_par` becomes 1 and `phase_err` becomes 0.
- R5: If the offset lies in the dead band (below 0.02, between 0.40 and 0.60, or above 0.98), `phase_err` becomes 1, no `field_vld` is produced and `field_par` keeps its value.
- R6: All three outputs change at the same clock edge that first samples `vsync_n` low. `field_vld` is high for exactly that one cycle. A rising edge of `vsync_n`, or `vsync_n` held low, produces no further pulse.
- R7: If no `hsync_n` falling edge arrives for more than TIMEOUT clocks (default 4096), `phase_err` rises at the edge TIMEOUT+1 clocks after the last one, and the period is discarded. Classification resumes only after two new horizontal edges.
- R8: Both window limits are inclusive. With a 1000-clock period, offsets 20, 400, 600 and 980 are accepted, and offsets 19, 401, 599 and 981 are rejected.
- R9: A vertical and a horizontal falling edge seen at the same clock edge give offset 0. That offset is in the dead band and is handled as in R5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| vsync_n | input | 1 | Vertical sync, active low, synchronous to clk |
| hsync_n | input | 1 | Horizontal sync, active low, equalizing pulses removed |
| field_par | output | 1 | Field type: 0 for the early window, 1 for the late window |
| field_vld | output | 1 | One-cycle strobe when a field has been classified |
| phase_err | output | 1 | Dead-band offset, unknown period, or lost horizontal sync |

## Verification
Every result of a vertical edge is due at the clock edge that samples `vsync_n` low. The bench therefore drives each sync change on a falling clock edge and reads the outputs at the next falling edge, one tick after the drive. It also counts `field_vld` pulses over the rest of each line and expects exactly one pulse or none. The sync-loss error is due TIMEOUT+1 edges after the last horizontal edge. The bench checks that `phase_err` is still low one tick before that point and high at it. Offsets are placed by counting ticks from the horizontal drive, so each boundary value lands on the clock it names.

// File: rtl/fpd_pkg.sv
package fpd_pkg;

    typedef enum logic [1:0] {
        WIN_DEAD  = 2'd0,
        WIN_EARLY = 2'd1,
        WIN_LATE  = 2'd2
    } win_e;

endpackage

// File: rtl/fpd_edge.sv
module fpd_edge (
    input  logic clk,
    input  logic rst,
    input  logic sync_n,
    output logic fall
);

    typedef struct packed {
        logic prev;
    } edge_s;

    edge_s st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = sync_n;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.prev <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fall = st_q.prev & ~sync_n;

endmodule

// File: rtl/fpd_line_timer.sv
module fpd_line_timer #(
    parameter int unsigned TIMEOUT = 4096,
    parameter int unsigned CNT_W   = 13
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hfall,
    output logic [CNT_W-1:0] offset,
    output logic [CNT_W-1:0] period,
    output logic             period_ok,
    output logic             lost
);

    localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(TIMEOUT + 1);
    localparam logic [CNT_W-1:0] CNT_TRIP = CNT_W'(TIMEOUT);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] period;
        logic             started;
        logic             ok;
    } tmr_s;

    tmr_s st_d, st_q;

    always_comb begin
        st_d = st_q;
        lost = 1'b0;
        if (hfall) begin
            st_d.cnt     = '0;
            st_d.period  = st_q.cnt + 1'b1;
            st_d.ok      = st_q.started;
            st_d.started = 1'b1;
        end else if (st_q.cnt != CNT_MAX) begin
            st_d.cnt = st_q.cnt + 1'b1;
            if (st_q.cnt == CNT_TRIP) begin
                lost         = 1'b1;
                st_d.started = 1'b0;
                st_d.ok      = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.cnt     <= CNT_MAX;
            st_q.period  <= '0;
            st_q.started <= 1'b0;
            st_q.ok      <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        if (hfall) begin
            offset = '0;
        end else if (st_q.cnt == CNT_MAX) begin
            offset = CNT_MAX;
        end else begin
            offset = st_q.cnt + 1'b1;
        end
    end

    assign period    = st_q.period;
    assign period_ok = st_q.ok;

    // R2: the period only moves on a horizontal edge
    p_period_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !hfall |=> $stable(period));

    // R2: a horizontal edge restarts the offset count
    p_offset_restart_r2: assert property (@(posedge clk) disable iff (rst)
        hfall |=> (hfall || offset == CNT_W'(1)));

    // R7: loss of sync invalidates the period
    p_lost_drops_period_r7: assert property (@(posedge clk) disable iff (rst)
        lost |=> !period_ok);

endmodule

// File: rtl/fpd_phase_window.sv
module fpd_phase_window
    import fpd_pkg::*;
#(
    parameter int unsigned CNT_W    = 13,
    parameter int unsigned SCALE    = 1000,
    parameter int unsigned EARLY_LO = 20,
    parameter int unsigned EARLY_HI = 400,
    parameter int unsigned LATE_LO  = 600,
    parameter int unsigned LATE_HI  = 980
) (
    input  logic [CNT_W-1:0] offset,
    input  logic [CNT_W-1:0] period,
    output win_e             win
);

    localparam int unsigned SCALE_W = $clog2(SCALE + 1);
    localparam int unsigned PROD_W  = CNT_W + SCALE_W;
    localparam int unsigned NLIM    = 4;

    logic [PROD_W-1:0] off_sc;
    logic [PROD_W-1:0] per_w;
    logic [NLIM-1:0]   hit;

    assign off_sc = PROD_W'(offset) * PROD_W'(SCALE);
    assign per_w  = PROD_W'(period);

    for (genvar k = 0; k < NLIM; k++) begin : g_lim
        localparam int unsigned LIM = (k == 0) ? EARLY_LO :
                                      (k == 1) ? EARLY_HI :
                                      (k == 2) ? LATE_LO  : LATE_HI;
        logic [PROD_W-1:0] lim_sc;
        assign lim_sc = per_w * PROD_W'(LIM);
        if (k % 2 == 0) begin : g_lower
            assign hit[k] = (off_sc >= lim_sc);
        end else begin : g_upper
            assign hit[k] = (off_sc <= lim_sc);
        end
    end

    always_comb begin
        if (hit[0] && hit[1]) begin
            win = WIN_EARLY;
        end else if (hit[2] && hit[3]) begin
            win = WIN_LATE;
        end else begin
            win = WIN_DEAD;
        end
    end

endmodule

// File: rtl/fpd_classifier.sv
module fpd_classifier
    import fpd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic vfall,
    input  logic period_ok,
    input  logic lost,
    input  win_e win,
    output logic field_par,
    output logic field_vld,
    output logic phase_err
);

    typedef struct packed {
        logic par;
        logic vld;
        logic err;
    } cls_s;

    cls_s st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        if (lost) begin
            st_d.err = 1'b1;
        end else if (vfall) begin
            if (period_ok && win == WIN_EARLY) begin
                st_d.par = 1'b0;
                st_d.vld = 1'b1;
                st_d.err = 1'b0;
            end else if (period_ok && win == WIN_LATE) begin
                st_d.par = 1'b1;
                st_d.vld = 1'b1;
                st_d.err = 1'b0;
            end else begin
                st_d.err = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign field_par = st_q.par;
    assign field_vld = st_q.vld;
    assign phase_err = st_q.err;

    // R3, R4: a classified field never carries an error
    p_vld_clean_r4: assert property (@(posedge clk) disable iff (rst)
        field_vld |-> !phase_err);

    // R5: parity only moves together with a valid strobe
    p_par_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !$stable(field_par) |-> field_vld);

    // R6: a strobe follows a vertical falling edge
    p_vld_from_edge_r6: assert property (@(posedge clk) disable iff (rst)
        field_vld |-> $past(vfall));

    // R6: the strobe lasts one cycle
    p_vld_single_r6: assert property (@(posedge clk) disable iff (rst)
        field_vld |=> !field_vld);

endmodule

// File: rtl/field_parity_det.sv
module field_parity_det
    import fpd_pkg::*;
#(
    parameter int unsigned TIMEOUT  = 4096,
    parameter int unsigned SCALE    = 1000,
    parameter int unsigned EARLY_LO = 20,
    parameter int unsigned EARLY_HI = 400,
    parameter int unsigned LATE_LO  = 600,
    parameter int unsigned LATE_HI  = 980
) (
    input  logic clk,
    input  logic rst,
    input  logic vsync_n,
    input  logic hsync_n,
    output logic field_par,
    output logic field_vld,
    output logic phase_err
);

    localparam int unsigned CNT_W  = $clog2(TIMEOUT + 2);
    localparam int unsigned NSYNC  = 2;
    localparam int unsigned IDX_H  = 0;
    localparam int unsigned IDX_V  = 1;

    logic [NSYNC-1:0] sync_vec;
    logic [NSYNC-1:0] fall_vec;
    logic             hfall;
    logic             vfall;
    logic [CNT_W-1:0] offset;
    logic [CNT_W-1:0] period;
    logic             period_ok;
    logic             lost;
    win_e             win;

    assign sync_vec[IDX_H] = hsync_n;
    assign sync_vec[IDX_V] = vsync_n;

    for (genvar s = 0; s < NSYNC; s++) begin : g_edge
        fpd_edge u_edge (
            .clk    (clk),
            .rst    (rst),
            .sync_n (sync_vec[s]),
            .fall   (fall_vec[s])
        );
    end

    assign hfall = fall_vec[IDX_H];
    assign vfall = fall_vec[IDX_V];

    fpd_line_timer #(
        .TIMEOUT (TIMEOUT),
        .CNT_W   (CNT_W)
    ) u_timer (
        .clk       (clk),
        .rst       (rst),
        .hfall     (hfall),
        .offset    (offset),
        .period    (period),
        .period_ok (period_ok),
        .lost      (lost)
    );

    fpd_phase_window #(
        .CNT_W    (CNT_W),
        .SCALE    (SCALE),
        .EARLY_LO (EARLY_LO),
        .EARLY_HI (EARLY_HI),
        .LATE_LO  (LATE_LO),
        .LATE_HI  (LATE_HI)
    ) u_window (
        .offset (offset),
        .period (period),
        .win    (win)
    );

    fpd_classifier u_cls (
        .clk       (clk),
        .rst       (rst),
        .vfall     (vfall),
        .period_ok (period_ok),
        .lost      (lost),
        .win       (win),
        .field_par (field_par),
        .field_vld (field_vld),
        .phase_err (phase_err)
    );

    // R7: losing the horizontal sync raises the error flag
    p_lost_err_r7: assert property (@(posedge clk) disable iff (rst)
        lost |=> phase_err);

    // R2: a vertical edge without a known period is an error
    p_no_period_r2: assert property (@(posedge clk) disable iff (rst)
        (vfall && !period_ok) |=> (phase_err && !field_vld));

endmodule

// File: tb/field_parity_det_tb.sv
module field_parity_det_tb;

    localparam int TIMEOUT = 4096;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic vsync_n = 1'b1;
    logic hsync_n = 1'b1;
    logic field_par;
    logic field_vld;
    logic phase_err;

    int checks = 0;
    int errors = 0;
    int hcnt = 0;
    int vcnt = 0;
    logic s_par, s_vld, s_err;

    always #2.5 clk = ~clk;

    field_parity_det #(.TIMEOUT(TIMEOUT)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .vsync_n   (vsync_n),
        .hsync_n   (hsync_n),
        .field_par (field_par),
        .field_vld (field_vld),
        .phase_err (phase_err)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // samples the outputs, then drives the syncs for the next clock
    task automatic tick(input bit hs, input bit vs);
        @(negedge clk);
        s_par = field_par;
        s_vld = field_vld;
        s_err = phase_err;
        if (hs) hcnt = 8;
        if (vs) vcnt = 30;
        hsync_n = !(hcnt > 0);
        vsync_n = !(vcnt > 0);
        if (hcnt > 0) hcnt--;
        if (vcnt > 0) vcnt--;
    endtask

    // one line of 'period' ticks, vertical edge at 'voff' (negative: none)
    task automatic run_line(input int period, input int voff, input bit ev,
                            input bit ep, input bit ee, input string tag);
        int pulses = 0;
        for (int i = 0; i < period; i++) begin
            tick(i == 0, i == voff);
            if (i > 0 && s_vld) pulses++;
            if (voff >= 0 && i == voff + 1) begin
                chk({tag, " vld"}, s_vld, ev);
                chk({tag, " par"}, s_par, ep);
                chk({tag, " err"}, s_err, ee);
            end
        end
        if (voff >= 0) chk({tag, " R6 pulse count"}, pulses, ev ? 1 : 0);
    endtask

    task automatic field(input int period, input int voff, input bit ev,
                         input bit ep, input bit ee, input string tag);
        run_line(period, -1, 0, 0, 0, tag);
        run_line(period, voff, ev, ep, ee, tag);
    endtask

    task automatic t_reset;
        repeat (4) @(negedge clk);
        chk("R1 par in reset", field_par, 0);
        chk("R1 vld in reset", field_vld, 0);
        chk("R1 err in reset", phase_err, 0);
        rst = 1'b0;
        repeat (3) tick(0, 0);
        chk("R1 par after reset", s_par, 0);
        chk("R1 vld after reset", s_vld, 0);
        chk("R1 err after reset", s_err, 0);
    endtask

    task automatic t_no_period;
        run_line(1000, 100, 0, 0, 1, "R2 single edge");
    endtask

    task automatic t_windows;
        field(1000, 200, 1, 0, 0, "R3 early");
        field(1000, 700, 1, 1, 0, "R4 late");
        field(1000, 500, 0, 1, 1, "R5 mid dead band");
        field(300, 60, 1, 0, 0, "R3 short line");
        field(300, 240, 1, 1, 0, "R4 short line");
    endtask

    task automatic t_bounds;
        field(1000, 980, 1, 1, 0, "R8 late hi 980");
        field(1000, 981, 0, 1, 1, "R8 late hi 981");
        field(1000, 600, 1, 1, 0, "R8 late lo 600");
        field(1000, 599, 0, 1, 1, "R8 late lo 599");
        field(1000, 400, 1, 0, 0, "R8 early hi 400");
        field(1000, 401, 0, 0, 1, "R8 early hi 401");
        field(1000, 20, 1, 0, 0, "R8 early lo 20");
        field(1000, 19, 0, 0, 1, "R8 early lo 19");
    endtask

    task automatic t_coincident;
        field(1000, 200, 1, 0, 0, "R9 setup");
        field(1000, 0, 0, 0, 1, "R9 coincident");
    endtask

    task automatic t_timeout;
        field(1000, 300, 1, 0, 0, "R7 setup");
        tick(1, 0);
        for (int k = 1; k <= TIMEOUT + 2; k++) begin
            tick(0, 0);
            if (k == TIMEOUT + 1) chk("R7 err before limit", s_err, 0);
            if (k == TIMEOUT + 2) chk("R7 err at limit", s_err, 1);
        end
        run_line(1000, 100, 0, 0, 1, "R7 first edge after loss");
        run_line(1000, 300, 1, 0, 0, "R7 recovered");
    endtask

    initial begin
        int cyc = 0;
        while (cyc < 150000) begin
            @(posedge clk);
            cyc++;
        end
        errors++;
        $display("FAIL watchdog actual=%0d expected=0", cyc);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_no_period();
        t_windows();
        t_bounds();
        t_coincident();
        t_timeout();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule